// File: doc/BRIEF.md
# TDM Time Slot Router

This block divides one serial time-division-multiplexed frame among six internal serial channels and four external strobe lines. A frame sync pulse starts the frame. The block then walks a routing table one entry at a time. Each entry names the channel that owns the next run of bit slots and the strobes that are active during that run. The run is given as a number of bits or a number of bytes.

All logic runs on one bit clock, and the same table drives both directions. On receive, the line bit goes to the selected channel, qualified by a valid flag. On transmit, the selected channel is asked for its bit through a request flag, and that bit is put on the line.

The table has two banks. Host writes always go to the bank that is not in use. A swap command exchanges the two banks at the next accepted frame sync, so routing can change while traffic continues.

The streams are timed by the line, so there is no back-pressure. The valid and request flags are always honoured in the cycle in which they appear. A channel that is not ready still has its slot consumed, and the slot's receive bit is lost to it.

Top module: `tdm_slot_router`

## Requirements
- R1: Each entry is 13 bits: strobe mask [12:9], channel code [8:6], count [5:2], byte flag [1], last flag [0].
  - Channel codes 1 to 6 select channel index code-1. While that entry runs, `ch_rx_valid` and `ch_tx_req` are asserted only at that index.
  - Code 0 (skipped slot) and code 7 (strobe only) select no channel.
- R2: An entry lasts count+1 bit cycles when the byte flag is 0, and 8×(count+1) bit cycles when it is 1.
- R3: After the bit cycles of the entry with the last flag (or of the final table entry) have run, the block selects nothing and waits for a sync.
  - A sync that arrives while a frame is running is ignored, except in the final bit cycle of the frame.
  - A sync in that final bit cycle starts the next frame with no gap.
- R4: Bit i of the strobe mask drives `strobe[i]` for every bit cycle of the entry. If the same strobe is set in adjacent entries, it stays high across the boundary without a gap.
- R5: Outside echo mode, `txd` is 1 whenever no channel is selected: in skipped slots, in strobe-only slots, and between frames.
- R6: If `frame_sync` is sampled high at a clock edge, the first bit cycle of the frame is the cycle that begins `sync_dly` clock edges after that edge.
- R7: A table write stores into the bank that is not in use and does not change the frame routing in progress.
- R8: `swap_pend` rises the cycle after `swap_req` and stays high until the next accepted sync. At that edge the banks exchange, so the frame being started already uses the new bank, and `swap_done` pulses for one cycle.
- R9: In echo mode (`test_mode`=1), `txd` equals `rxd` in every cycle, and the receive routing is unchanged.
- R10: In loopback mode (`test_mode`=2), the receive path takes the block's own transmit bit instead of `rxd`.
- R11: In normal mode, a selected channel receives `rxd` on `ch_rx_bit`, and `txd` carries that channel's `ch_tx_bit`. At most one channel is selected in any cycle.
- R12: After reset, bank 0 is in use, no frame is running, `txd` is 1, no strobe or channel is selected, and `swap_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync pulse |
| sync_dly | input | DLY_W | Frame start delay, in bits |
| test_mode | input | 2 | 0 normal, 1 echo, 2 loopback |
| rxd | input | 1 | Receive line bit |
| txd | output | 1 | Transmit line bit |
| ch_rx_valid | output | 6 | Receive bit valid, one flag per channel |
| ch_rx_bit | output | 1 | Receive bit delivered to the selected channel |
| ch_tx_req | output | 6 | Transmit bit request, one flag per channel |
| ch_tx_bit | input | 6 | Transmit bit from each channel |
| strobe | output | 4 | External strobe outputs |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | $clog2(ENTRIES) | Table write address |
| tbl_wr_data | input | 13 | Table entry to write |
| swap_req | input | 1 | Request a bank swap |
| swap_pend | output | 1 | Swap requested but not yet done |
| swap_done | output | 1 | One-cycle pulse when the banks exchange |

## Verification
Two events can fall on the same clock edge: the final bit cycle of a frame and the accepted sync of the next frame. The bench drives sync exactly in that last cycle and expects the first entry's channel in the very next cycle.

It also raises sync in the middle of a byte-long entry and expects the routing to continue unchanged.

A bank swap is tied to sync acceptance. The bench therefore checks that the first bit of the frame already follows the new bank, in the same cycle that `swap_done` pulses.

// File: rtl/tdm_tsa_pkg.sv
package tdm_tsa_pkg;
  localparam int N_CH  = 6;
  localparam int N_STB = 4;
  localparam int ENT_W = 13;

  typedef struct packed {
    logic [3:0] stb;
    logic [2:0] chan;
    logic [3:0] cnt;
    logic       byt;
    logic       last;
  } tsa_entry_t;

  localparam logic [1:0] TM_ECHO = 2'd1;
  localparam logic [1:0] TM_LOOP = 2'd2;

  // Number of bit cycles in an entry, minus one.
  function automatic logic [6:0] run_bits(input tsa_entry_t e);
    return e.byt ? {e.cnt, 3'b111} : {3'b000, e.cnt};
  endfunction
endpackage

// File: rtl/tsa_table.sv
module tsa_table
  import tdm_tsa_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  tsa_entry_t    wr_data,
  input  logic          act_bank,
  input  logic [AW-1:0] rd_addr,
  output tsa_entry_t    rd_data
);
  tsa_entry_t mem [2][ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < ENTRIES; i++)
          mem[b][i] <= '0;
    end else if (wr_en) begin
      mem[~act_bank][wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[act_bank][rd_addr];
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tdm_tsa_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int DLY_W   = 2,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DLY_W-1:0] sync_dly,
  input  logic [6:0]       run_len,
  input  logic             ent_last,
  input  logic             swap_req,
  output logic [AW-1:0]    idx,
  output logic             act_bank,
  output logic             active,
  output logic             swap_pend,
  output logic             swap_done
);
  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_RUN} seq_state_t;

  seq_state_t       state;
  logic [6:0]       bpos;
  logic [DLY_W-1:0] dcnt;
  logic             end_ent, frame_end, accept;

  assign active    = (state == S_RUN);
  assign end_ent   = (bpos == run_len);
  assign frame_end = active && end_ent && (ent_last || idx == AW'(ENTRIES - 1));
  assign accept    = sync_in && (state == S_IDLE || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      bpos      <= '0;
      dcnt      <= '0;
      act_bank  <= 1'b0;
      swap_pend <= 1'b0;
      swap_done <= 1'b0;
    end else begin
      swap_done <= 1'b0;
      if (swap_req) swap_pend <= 1'b1;
      if (accept) begin
        if (swap_pend) begin
          act_bank  <= ~act_bank;
          swap_pend <= swap_req;
          swap_done <= 1'b1;
        end
        idx  <= '0;
        bpos <= '0;
        if (sync_dly == '0) begin
          state <= S_RUN;
        end else begin
          state <= S_DELAY;
          dcnt  <= sync_dly - DLY_W'(1);
        end
      end else begin
        case (state)
          S_DELAY: begin
            if (dcnt == '0) state <= S_RUN;
            else            dcnt  <= dcnt - DLY_W'(1);
          end
          S_RUN: begin
            if (end_ent) begin
              bpos <= '0;
              if (frame_end) state <= S_IDLE;
              else           idx   <= idx + AW'(1);
            end else begin
              bpos <= bpos + 7'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsa_route.sv
module tsa_route
  import tdm_tsa_pkg::*;
(
  input  logic             active,
  input  logic [2:0]       chan,
  input  logic [N_STB-1:0] stb,
  input  logic [1:0]       test_mode,
  input  logic             rxd,
  input  logic [N_CH-1:0]  tx_bits,
  output logic             txd,
  output logic             rx_bit,
  output logic [N_CH-1:0]  sel,
  output logic [N_STB-1:0] strobe
);
  logic tx_line;

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign sel[g] = active && (chan == 3'(g + 1));
  end

  assign tx_line = (|sel) ? |(sel & tx_bits) : 1'b1;
  assign txd     = (test_mode == TM_ECHO) ? rxd : tx_line;
  assign rx_bit  = (test_mode == TM_LOOP) ? tx_line : rxd;
  assign strobe  = active ? stb : '0;
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_tsa_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int DLY_W   = 2,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic [DLY_W-1:0] sync_dly,
  input  logic [1:0]       test_mode,
  input  logic             rxd,
  output logic             txd,
  output logic [5:0]       ch_rx_valid,
  output logic             ch_rx_bit,
  output logic [5:0]       ch_tx_req,
  input  logic [5:0]       ch_tx_bit,
  output logic [3:0]       strobe,
  input  logic             tbl_wr_en,
  input  logic [AW-1:0]    tbl_wr_addr,
  input  logic [12:0]      tbl_wr_data,
  input  logic             swap_req,
  output logic             swap_pend,
  output logic             swap_done
);
  tsa_entry_t    cur;
  logic [AW-1:0] idx;
  logic          act_bank, frame_act;
  logic [5:0]    sel;

  tsa_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
    .wr_data(tsa_entry_t'(tbl_wr_data)), .act_bank(act_bank),
    .rd_addr(idx), .rd_data(cur)
  );

  tsa_seq #(.ENTRIES(ENTRIES), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync_in(frame_sync), .sync_dly(sync_dly),
    .run_len(run_bits(cur)), .ent_last(cur.last), .swap_req(swap_req),
    .idx(idx), .act_bank(act_bank), .active(frame_act),
    .swap_pend(swap_pend), .swap_done(swap_done)
  );

  tsa_route u_route (
    .active(frame_act), .chan(cur.chan), .stb(cur.stb), .test_mode(test_mode),
    .rxd(rxd), .tx_bits(ch_tx_bit), .txd(txd), .rx_bit(ch_rx_bit),
    .sel(sel), .strobe(strobe)
  );

  assign ch_rx_valid = sel;
  assign ch_tx_req   = sel;
endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxd,
  input logic       txd,
  input logic       ch_rx_bit,
  input logic [5:0] ch_rx_valid,
  input logic [1:0] test_mode,
  input logic [3:0] strobe,
  input logic       swap_pend,
  input logic       swap_done,
  input logic       frame_act
);
  // R11
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rx_valid));

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != 2'd1 && ch_rx_valid == 6'd0) |-> txd);

  // R9
  echo_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd1) |-> (txd == rxd));

  // R10
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'd2) |-> (ch_rx_bit == txd));

  // R8
  swap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swap_pend) |-> swap_done);

  // R8
  swap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |-> $past(swap_pend));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |-> (strobe == 4'd0 && ch_rx_valid == 6'd0));
endmodule

bind tdm_slot_router tdm_slot_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .ch_rx_bit(ch_rx_bit),
  .ch_rx_valid(ch_rx_valid), .test_mode(test_mode), .strobe(strobe),
  .swap_pend(swap_pend), .swap_done(swap_done), .frame_act(frame_act)
);

// File: tb/tdm_slot_router_tb_top.sv
module tdm_slot_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic [1:0] sync_dly = 2'd0;
  logic [1:0] test_mode = 2'd0;
  logic       rxd = 1'b0;
  logic       txd;
  logic [5:0] ch_rx_valid, ch_tx_req;
  logic       ch_rx_bit;
  logic [5:0] ch_tx_bit = 6'b101010;
  logic [3:0] strobe;
  logic       tbl_wr_en = 1'b0;
  logic [4:0] tbl_wr_addr = '0;
  logic [12:0] tbl_wr_data = '0;
  logic       swap_req = 1'b0;
  logic       swap_pend, swap_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_router dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .sync_dly(sync_dly),
    .test_mode(test_mode), .rxd(rxd), .txd(txd), .ch_rx_valid(ch_rx_valid),
    .ch_rx_bit(ch_rx_bit), .ch_tx_req(ch_tx_req), .ch_tx_bit(ch_tx_bit),
    .strobe(strobe), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .swap_req(swap_req), .swap_pend(swap_pend),
    .swap_done(swap_done)
  );

  // Per-cycle expectations: {sync driven, channel flags, strobes, txd}
  localparam logic [11:0] VEC [16] = '{
    12'b0_000001_0001_0, 12'b0_000001_0001_0, 12'b0_000000_0000_1,
    12'b0_000000_0010_1, 12'b0_000000_0010_1, 12'b0_010000_0000_0,
    12'b1_010000_0000_0, 12'b0_010000_0000_0, 12'b0_010000_0000_0,
    12'b0_010000_0000_0, 12'b0_010000_0000_0, 12'b0_010000_0000_0,
    12'b0_010000_0000_0, 12'b0_000100_0100_0, 12'b0_000000_0000_1,
    12'b0_000000_0000_1
  };

  function automatic logic [12:0] mk(input logic [3:0] s, input logic [2:0] c,
                                     input logic [3:0] n, input logic b, input logic l);
    return {s, c, n, b, l};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [12:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = 5'(a); tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic start_frame();
    @(negedge clk);
    frame_sync = 1'b1;
  endtask

  task automatic step(input logic s, input logic r);
    @(negedge clk);
    frame_sync = s; rxd = r; swap_req = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 txd", 32'(txd), 32'd1);
    chk("R12 strobe", 32'(strobe), 32'd0);
    chk("R12 valid", 32'(ch_rx_valid), 32'd0);
    chk("R12 swap_pend", 32'(swap_pend), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Load shadow bank (bank 1) then request a swap
    wr(0, mk(4'b0001, 3'd1, 4'd1, 1'b0, 1'b0));
    wr(1, mk(4'b0000, 3'd0, 4'd0, 1'b0, 1'b0));
    wr(2, mk(4'b0010, 3'd7, 4'd0, 1'b0, 1'b0));
    wr(3, mk(4'b0010, 3'd7, 4'd0, 1'b0, 1'b0));
    wr(4, mk(4'b0000, 3'd5, 4'd0, 1'b1, 1'b0));
    wr(5, mk(4'b0100, 3'd3, 4'd0, 1'b0, 1'b1));
    @(negedge clk); swap_req = 1'b1;
    step(1'b0, 1'b0);
    chk("R8 pend", 32'(swap_pend), 32'd1);

    // Vector walk: R1 R2 R3 R4 R5 R11
    start_frame();
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][11], i[0]);
      chk("R1 valid", 32'(ch_rx_valid), 32'(VEC[i][10:5]));
      chk("R11 req", 32'(ch_tx_req), 32'(VEC[i][10:5]));
      chk("R4 strobe", 32'(strobe), 32'(VEC[i][4:1]));
      chk("R5 txd", 32'(txd), 32'(VEC[i][0]));
      if (VEC[i][10:5] != 6'd0) chk("R11 rxbit", 32'(ch_rx_bit), 32'(i[0]));
      if (i == 0) chk("R8 done", 32'(swap_done), 32'd1);
      if (i == 0) chk("R8 cleared", 32'(swap_pend), 32'd0);
      if (i == 1) chk("R8 pulse", 32'(swap_done), 32'd0);
      if (i == 12) chk("R2 byte run", 32'(ch_rx_valid), 32'h10);
    end

    // R3 back-to-back frames: sync in last bit cycle
    start_frame();
    for (int i = 0; i < 13; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R3 last bit", 32'(ch_rx_valid), 32'h04);
    step(1'b0, 1'b0);
    chk("R3 no gap", 32'(ch_rx_valid), 32'h01);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0);

    // R7 write to shadow does not alter routing
    wr(0, mk(4'b0000, 3'd2, 4'd0, 1'b0, 1'b1));
    start_frame();
    step(1'b0, 1'b0);
    chk("R7 unchanged", 32'(ch_rx_valid), 32'h01);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0);

    // R8 swap makes new bank live on the next frame
    @(negedge clk); swap_req = 1'b1;
    step(1'b0, 1'b0);
    start_frame();
    step(1'b0, 1'b0);
    chk("R8 new bank", 32'(ch_rx_valid), 32'h02);
    step(1'b0, 1'b0);
    chk("R3 idle after last", 32'(ch_rx_valid), 32'h00);

    // R6 sync delay of two bits
    sync_dly = 2'd2;
    start_frame();
    step(1'b0, 1'b0);
    chk("R6 delay c1", 32'(ch_rx_valid), 32'h00);
    step(1'b0, 1'b0);
    chk("R6 delay c2", 32'(ch_rx_valid), 32'h00);
    step(1'b0, 1'b0);
    chk("R6 first slot", 32'(ch_rx_valid), 32'h02);
    step(1'b0, 1'b0);
    sync_dly = 2'd0;

    // R10 loopback
    test_mode = 2'd2; ch_tx_bit = 6'b000000;
    start_frame();
    step(1'b0, 1'b1);
    chk("R10 loop rxbit", 32'(ch_rx_bit), 32'd0);
    chk("R10 loop txd", 32'(txd), 32'd0);
    step(1'b0, 1'b1);

    // R9 echo
    test_mode = 2'd1;
    step(1'b0, 1'b0);
    chk("R9 echo 0", 32'(txd), 32'd0);
    step(1'b0, 1'b1);
    chk("R9 echo 1", 32'(txd), 32'd1);
    test_mode = 2'd0;
    step(1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule